// File: doc/BRIEF.md
# Strip Trigger Energy Pipeline

This block turns five crystal channels of one calorimeter strip into a trigger primitive. A new sample arrives on every channel at each clock. Each sample is a 12-bit ADC reading plus a 2-bit code that says which of four amplifier gains produced it.

Every channel is brought onto one 18-bit energy scale through a programmable multiplier and right shift, picked by its gain code. The five values are added into a strip sum. The sum passes through a five-tap signed FIR filter, and a three-point peak finder marks the bunch crossing where the filtered pulse is largest. At that crossing the block presents the filtered strip energy and a fine-grain bit. The fine-grain bit says whether one crystal carries more than a programmable fraction of the strip energy.

Coefficients are loaded through a one-cycle register write port. The whole path from input to flagged output runs well inside a nine-cycle budget.

Top module: `strip_trig_pipe`

## Requirements
- R1: Each channel is linearized as min((adc × mult) >> shift, 262143). The gain code g (0..3) selects the table entry at write address g, with the multiplier in write data bits [11:0] and the shift in bits [15:12]. After reset every entry holds multiplier 1 and shift 0.
- R2: The strip sum is the plain sum of the five linearized channel values.
- R3: The filter output is the sum over k = 0..4 of w[k] × sum(n−k). The signed 8-bit weight w[k] is written at address 4+k, in write data bits [7:0]. After reset w[0] = 1 and all other weights are 0. A negative filter result is replaced by zero.
- R4: A filtered value f(n) is reported only when f(n) > f(n−1) and f(n) ≥ f(n+1). A flat top of equal values is therefore reported once, on its first sample, and two adjacent crossings are never both reported.
- R5: A reported crossing appears on trig_valid exactly five clock edges after the edge that captures that crossing's input samples.
- R6: No crossing whose input samples are captured on the first five clock edges after reset release is ever reported. A crossing captured on the sixth edge can be reported.
- R7: trig_energy carries the filtered value at the reported crossing, limited to 262143.
- R8: trig_fg is 1 when the largest linearized channel of the reported crossing is strictly greater than the strip sum shifted right by the fraction shift. The fraction shift is written at address 9, in write data bits [3:0], and is 1 after reset.
- R9: While trig_valid is low, trig_energy and trig_fg are zero. All three outputs are zero during and right after reset.
- R10: Configuration state changes only on a clock edge with cfg_we high and a mapped address (0..9). Writes to addresses 10..15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adc_in | input | 60 | Five 12-bit ADC samples, channel c at bits [12c+11:12c] |
| gain_in | input | 10 | Five 2-bit gain codes, channel c at bits [2c+1:2c] |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| trig_valid | output | 1 | High for one cycle at a reported peak crossing |
| trig_energy | output | 18 | Filtered strip energy at the peak |
| trig_fg | output | 1 | Fine-grain bit at the peak |

## Verification
The fill gate and the peak finder can act in the same cycle. The earliest crossing the delay line can support is the one whose peak decision falls on the first edge after the gate opens. To provoke this, the bench resets the block and then fires a single impulse captured on the fifth edge, followed by one captured on the sixth. The first must produce no trig_valid at all. The second must produce exactly one trig_valid, carrying the full impulse energy, on the predicted edge.

// File: rtl/strip_trig_pkg.sv
package strip_trig_pkg;
  localparam int ADC_W  = 12;
  localparam int GAIN_W = 2;
  localparam int NGAIN  = 1 << GAIN_W;
  localparam int LIN_W  = 18;
  localparam int MUL_W  = 12;
  localparam int SHF_W  = 4;
  localparam int COEF_W = 8;
  localparam int CFG_AW = 4;
  localparam int CFG_DW = MUL_W + SHF_W;
  localparam int PROD_W = ADC_W + MUL_W;

  typedef logic [LIN_W-1:0] lin_t;
  localparam lin_t LIN_MAX = '1;

  // Gain-ranged sample to common energy scale, saturating.
  function automatic lin_t lin_calc(input logic [ADC_W-1:0] adc,
                                    input logic [MUL_W-1:0] mul,
                                    input logic [SHF_W-1:0] sh);
    logic [PROD_W-1:0] prod;
    prod = ({{MUL_W{1'b0}}, adc} * {{ADC_W{1'b0}}, mul}) >> sh;
    if (prod > PROD_W'(LIN_MAX)) return LIN_MAX;
    return prod[LIN_W-1:0];
  endfunction

  // Fine-grain decision: one crystal dominates a fraction of the strip.
  function automatic logic fg_calc(input logic [31:0] mx,
                                   input logic [31:0] sm,
                                   input logic [SHF_W-1:0] sh);
    return mx > (sm >> sh);
  endfunction
endpackage

// File: rtl/strip_lin_chan.sv
module strip_lin_chan
  import strip_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADC_W-1:0] adc,
  input  logic [MUL_W-1:0] mul,
  input  logic [SHF_W-1:0] shf,
  output lin_t             lin_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lin_q <= '0;
    else        lin_q <= lin_calc(adc, mul, shf);
  end
endmodule

// File: rtl/strip_fir.sv
module strip_fir
  import strip_trig_pkg::*;
#(
  parameter int NTAP   = 5,
  parameter int SUM_W  = 21,
  parameter int ACC_W  = 33,
  parameter int FILT_W = ACC_W - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SUM_W-1:0]         sum_in,
  input  logic                     fg_in,
  input  logic [NTAP*COEF_W-1:0]   tap_flat,
  output logic [FILT_W-1:0]        filt_q,
  output logic                     fg_q
);
  logic [SUM_W-1:0]         dl [NTAP];
  logic signed [COEF_W-1:0] w_s [NTAP];
  logic signed [ACC_W-1:0]  acc;
  logic                     fg_dl;
  logic                     acc_neg;

  for (genvar g = 0; g < NTAP; g++) begin : g_wt
    assign w_s[g] = tap_flat[g*COEF_W +: COEF_W];
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAP; k++)
      acc = acc + (ACC_W'(w_s[k]) * ACC_W'(signed'({1'b0, dl[k]})));
  end

  assign acc_neg = acc[ACC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAP; k++) dl[k] <= '0;
      fg_dl  <= 1'b0;
      filt_q <= '0;
      fg_q   <= 1'b0;
    end else begin
      dl[0] <= sum_in;
      for (int k = 1; k < NTAP; k++) dl[k] <= dl[k-1];
      fg_dl  <= fg_in;
      filt_q <= acc_neg ? '0 : acc[FILT_W-1:0];
      fg_q   <= fg_dl;
    end
  end
endmodule

// File: rtl/strip_peak.sv
module strip_peak
  import strip_trig_pkg::*;
#(
  parameter int FILT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FILT_W-1:0] filt_in,
  input  logic              fg_in,
  input  logic              arm,
  output logic              peak_hit,
  output logic              trig_valid,
  output lin_t              trig_energy,
  output logic              trig_fg
);
  logic [FILT_W-1:0] f_mid, f_old;
  logic              fg_mid;
  lin_t              e_sat;

  assign peak_hit = arm && (f_mid > f_old) && (f_mid >= filt_in);
  assign e_sat    = (f_mid > FILT_W'(LIN_MAX)) ? LIN_MAX : f_mid[LIN_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_mid       <= '0;
      f_old       <= '0;
      fg_mid      <= 1'b0;
      trig_valid  <= 1'b0;
      trig_energy <= '0;
      trig_fg     <= 1'b0;
    end else begin
      f_mid       <= filt_in;
      f_old       <= f_mid;
      fg_mid      <= fg_in;
      trig_valid  <= peak_hit;
      trig_energy <= peak_hit ? e_sat : '0;
      trig_fg     <= peak_hit & fg_mid;
    end
  end
endmodule

// File: rtl/strip_trig_pipe.sv
module strip_trig_pipe
  import strip_trig_pkg::*;
#(
  parameter int NCH  = 5,
  parameter int NTAP = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*ADC_W-1:0]  adc_in,
  input  logic [NCH*GAIN_W-1:0] gain_in,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [CFG_DW-1:0]     cfg_wdata,
  output logic                  trig_valid,
  output logic [LIN_W-1:0]      trig_energy,
  output logic                  trig_fg
);
  localparam int SUM_W    = LIN_W + $clog2(NCH);
  localparam int ACC_W    = SUM_W + COEF_W + $clog2(NTAP) + 1;
  localparam int FILT_W   = ACC_W - 1;
  localparam int TAP_BASE = NGAIN;
  localparam int FG_ADDR  = NGAIN + NTAP;
  localparam int FILL_CYC = NTAP + 5;
  localparam int CNT_W    = $clog2(FILL_CYC + 1);

  // configuration state
  logic [MUL_W-1:0]         g_mul [NGAIN];
  logic [SHF_W-1:0]         g_shf [NGAIN];
  logic [NTAP*COEF_W-1:0]   tap_flat;
  logic [SHF_W-1:0]         fg_shf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NGAIN; g++) begin
        g_mul[g] <= MUL_W'(1);
        g_shf[g] <= '0;
      end
      tap_flat <= (NTAP*COEF_W)'(1);
      fg_shf   <= SHF_W'(1);
    end else if (cfg_we) begin
      for (int g = 0; g < NGAIN; g++)
        if (cfg_addr == CFG_AW'(g)) begin
          g_mul[g] <= cfg_wdata[MUL_W-1:0];
          g_shf[g] <= cfg_wdata[CFG_DW-1 -: SHF_W];
        end
      for (int k = 0; k < NTAP; k++)
        if (cfg_addr == CFG_AW'(TAP_BASE + k))
          tap_flat[k*COEF_W +: COEF_W] <= cfg_wdata[COEF_W-1:0];
      if (cfg_addr == CFG_AW'(FG_ADDR))
        fg_shf <= cfg_wdata[SHF_W-1:0];
    end
  end

  // per-channel linearization
  lin_t lin_q [NCH];
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [GAIN_W-1:0] gsel;
    assign gsel = gain_in[ch*GAIN_W +: GAIN_W];
    strip_lin_chan u_lin (
      .clk   (clk),
      .rst_n (rst_n),
      .adc   (adc_in[ch*ADC_W +: ADC_W]),
      .mul   (g_mul[gsel]),
      .shf   (g_shf[gsel]),
      .lin_q (lin_q[ch])
    );
  end

  // strip sum and dominant crystal
  logic [SUM_W-1:0] sum_c, sum_q;
  lin_t             max_c, max_q;
  logic             fg_c;

  always_comb begin
    sum_c = '0;
    max_c = '0;
    for (int i = 0; i < NCH; i++) begin
      sum_c = sum_c + SUM_W'(lin_q[i]);
      if (lin_q[i] > max_c) max_c = lin_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      max_q <= '0;
    end else begin
      sum_q <= sum_c;
      max_q <= max_c;
    end
  end

  assign fg_c = fg_calc(32'(max_q), 32'(sum_q), fg_shf);

  // delay-line fill gate
  logic [CNT_W-1:0] fill_cnt;
  logic             fill_done;
  assign fill_done = (fill_cnt == CNT_W'(FILL_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fill_cnt <= '0;
    else if (!fill_done) fill_cnt <= fill_cnt + 1'b1;
  end

  // filter and peak finder
  logic [FILT_W-1:0] filt_q;
  logic              fg_filt;
  logic              peak_hit;

  strip_fir #(.NTAP(NTAP), .SUM_W(SUM_W), .ACC_W(ACC_W), .FILT_W(FILT_W)) u_fir (
    .clk      (clk),
    .rst_n    (rst_n),
    .sum_in   (sum_q),
    .fg_in    (fg_c),
    .tap_flat (tap_flat),
    .filt_q   (filt_q),
    .fg_q     (fg_filt)
  );

  strip_peak #(.FILT_W(FILT_W)) u_peak (
    .clk         (clk),
    .rst_n       (rst_n),
    .filt_in     (filt_q),
    .fg_in       (fg_filt),
    .arm         (fill_done),
    .peak_hit    (peak_hit),
    .trig_valid  (trig_valid),
    .trig_energy (trig_energy),
    .trig_fg     (trig_fg)
  );
endmodule

// File: rtl/strip_trig_chk.sv
module strip_trig_chk
  import strip_trig_pkg::*;
#(
  parameter int NTAP = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   trig_valid,
  input logic [LIN_W-1:0]       trig_energy,
  input logic                   cfg_we,
  input logic [NTAP*COEF_W-1:0] tap_flat
);
  localparam int FIRST_OUT = NTAP + 6;

  logic [7:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != '1)  age <= age + 8'd1;
  end

  AST_FILL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> (int'(age) >= FIRST_OUT)); // R6

  AST_NO_ADJ_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |=> !trig_valid); // R4

  AST_PEAK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> (trig_energy != '0)); // R7

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(tap_flat)); // R10
endmodule

bind strip_trig_pipe strip_trig_chk #(.NTAP(NTAP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trig_valid  (trig_valid),
  .trig_energy (trig_energy),
  .cfg_we      (cfg_we),
  .tap_flat    (tap_flat)
);

// File: tb/strip_trig_pipe_tb.sv
`timescale 1ns/1ps
module strip_trig_pipe_tb;
  localparam int NCH = 5;
  localparam int NV  = 9;
  localparam int SAT = 262143;

  // stimulus table: adc per channel, gain per channel, expected energy, fg
  localparam int VADC [NV][NCH] = '{
    '{100, 0, 0, 0, 0},
    '{0, 200, 0, 0, 0},
    '{0, 0, 300, 0, 0},
    '{0, 0, 0, 0, 4095},
    '{100, 100, 100, 100, 100},
    '{200, 200, 0, 0, 0},
    '{300, 100, 100, 100, 100},
    '{0, 0, 0, 1, 0},
    '{10, 10, 10, 0, 0}
  };
  localparam int VGAIN [NV][NCH] = '{
    '{0, 0, 0, 0, 0},
    '{0, 1, 0, 0, 0},
    '{0, 0, 2, 0, 0},
    '{0, 0, 0, 0, 3},
    '{0, 0, 0, 0, 0},
    '{0, 0, 0, 0, 0},
    '{0, 0, 0, 0, 0},
    '{0, 0, 0, 3, 0},
    '{1, 2, 3, 0, 0}
  };
  localparam int VEXP_E  [NV] = '{100, 1000, 2700, 135135, 500, 400, 700, 33, 470};
  localparam int VEXP_FG [NV] = '{1, 1, 1, 1, 0, 0, 0, 1, 1};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [59:0] adc_in = '0;
  logic [9:0]  gain_in = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        trig_valid;
  logic [17:0] trig_energy;
  logic        trig_fg;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  int cur_adc [NCH];
  int cur_gain [NCH];

  always #5 clk = ~clk;

  strip_trig_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .adc_in(adc_in), .gain_in(gain_in),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .trig_valid(trig_valid), .trig_energy(trig_energy), .trig_fg(trig_fg)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_cur();
    for (int c = 0; c < NCH; c++) begin cur_adc[c] = 0; cur_gain[c] = 0; end
  endtask

  task automatic drive_cur();
    for (int c = 0; c < NCH; c++) begin
      adc_in[c*12 +: 12] = 12'(cur_adc[c]);
      gain_in[c*2 +: 2]  = 2'(cur_gain[c]);
    end
  endtask

  task automatic drive_zero();
    adc_in  = '0;
    gain_in = '0;
  endtask

  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
  endtask

  task automatic set_taps(input int w0, input int w1, input int w2, input int w3, input int w4);
    cfg_write(4, w0 & 8'hFF); cfg_write(5, w1 & 8'hFF); cfg_write(6, w2 & 8'hFF);
    cfg_write(7, w3 & 8'hFF); cfg_write(8, w4 & 8'hFF);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drive_zero();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive the current pattern for 'hold' cycles, then zeros; watch 14 edges.
  task automatic fire(input int hold, input int exp_k, input int exp_e,
                      input int exp_fg, input string req);
    int seen_n = 0;
    int seen_k = 0;
    int got_e  = 0;
    int got_fg = 0;
    bit quiet  = 1'b1;
    @(negedge clk);
    drive_cur();
    for (int k = 1; k <= 14; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == hold) drive_zero();
      if (trig_valid) begin
        seen_n++; seen_k = k; got_e = int'(trig_energy); got_fg = int'(trig_fg);
      end else if (trig_energy != '0 || trig_fg) begin
        quiet = 1'b0;
      end
    end
    if (exp_k == 0) begin
      chk(seen_n == 0, req, seen_n, 0);
    end else begin
      chk(seen_n == 1 && seen_k == exp_k, req, seen_k, exp_k);
      chk(got_e == exp_e, req, got_e, exp_e);
      chk(got_fg == exp_fg, req, got_fg, exp_fg);
    end
    chk(quiet, "R9", quiet, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9: outputs quiet straight after reset
    chk(trig_valid == 1'b0 && trig_energy == '0 && trig_fg == 1'b0, "R9",
        {trig_valid, trig_energy, trig_fg}, 0);
    repeat (12) @(posedge clk);

    // R1: gain table 1, 5, 9, and 264>>3 = 33
    cfg_write(0, 16'h0001);
    cfg_write(1, 16'h0005);
    cfg_write(2, 16'h0009);
    cfg_write(3, (3 << 12) | 264);

    // table walk: R1 R2 R5 R7 R8 with tap w0 = 1 and fraction shift 1
    for (int i = 0; i < NV; i++) begin
      for (int c = 0; c < NCH; c++) begin cur_adc[c] = VADC[i][c]; cur_gain[c] = VGAIN[i][c]; end
      fire(1, 6, VEXP_E[i], VEXP_FG[i], "R1/R2/R5/R8");
    end

    // R8: fraction shift 2 makes 300 > 700>>2
    cfg_write(9, 2);
    clear_cur(); cur_adc[0] = 300;
    for (int c = 1; c < NCH; c++) cur_adc[c] = 100;
    fire(1, 6, 700, 1, "R8");
    cfg_write(9, 1);

    // R4: flat top of two equal samples reported once, on the first
    clear_cur(); cur_adc[0] = 100;
    fire(2, 6, 100, 1, "R4");

    // R3: weights 1,2,1 move the peak one crossing later with energy 2x
    set_taps(1, 2, 1, 0, 0);
    clear_cur(); cur_adc[0] = 100;
    fire(1, 7, 200, 0, "R3");

    // R3: weights -1,1; negative first result clamps to zero
    set_taps(-1, 1, 0, 0, 0);
    fire(1, 7, 100, 0, "R3");

    // R7: heavy weight saturates the reported energy
    set_taps(127, 0, 0, 0, 0);
    clear_cur(); cur_adc[4] = 4095; cur_gain[4] = 3;
    fire(1, 6, SAT, 1, "R7");

    // R1/R8: two saturated channels, max equals sum>>1 so fg stays low
    set_taps(1, 0, 0, 0, 0);
    cfg_write(3, 4095);
    clear_cur(); cur_adc[0] = 4095; cur_gain[0] = 3; cur_adc[1] = 4095; cur_gain[1] = 3;
    fire(1, 6, SAT, 0, "R1");

    // R10: unmapped addresses leave taps, gains and fraction untouched
    cfg_write(12, 16'hFFFF);
    cfg_write(15, 16'hFFFF);
    cfg_write(10, 16'h8080);
    clear_cur(); cur_adc[0] = 100;
    fire(1, 6, 100, 1, "R10");

    // R6: impulse captured on edge 5 after reset is never reported
    do_reset();
    repeat (4) @(posedge clk);
    clear_cur(); cur_adc[0] = 50;
    fire(1, 0, 0, 0, "R6");

    // R6: impulse captured on edge 6 after reset is reported (defaults)
    do_reset();
    repeat (5) @(posedge clk);
    clear_cur(); cur_adc[0] = 50;
    fire(1, 6, 50, 1, "R6");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule